// File: doc/BRIEF.md
# Sixteen-Level Priority Interrupt Controller

This block arbitrates between a set of interrupt sources and a small group of non-maskable hardware trap causes, and tells the CPU which one to take next. Every source owns a control word made of a pending bit, an enable bit and a 4-bit priority. The controller keeps the current CPU priority. It presents the strongest eligible request together with its vector number and level. When the CPU acknowledges, the controller records the old priority on an internal stack, and a return restores it.

Hardware traps sit above every ordinary level in three ordered classes. Each cause sets its own sticky bit in a trap flag word, which software clears by writing zeros. Causes of the lowest class share one vector. The block produces only a vector number. Fetching the handler is the CPU's job.

Levels are coded on 5 bits: 0..15 are ordinary levels, 16 is trap class I, 17 is class II and 18 is class III. Trap cause 0 is class III, cause 1 is class II, and every other cause is class I. Vectors 0, 1 and 2 belong to trap classes III, II and I. Ordinary source i uses vector 4+i.

Top module: `prio_intc`

## Requirements
- R1: A pulse on `src_evt[i]` sets that source's pending bit on the next clock edge. A write of the control word (bits [3:0] priority, bit 4 enable, bit 5 pending) replaces all three fields. `cfg_rdata` shows the selected word in the same layout.
- R2: An ordinary source is offered only when it is pending, enabled, and its priority is strictly greater than `cpu_prio`. A request at the same level as the current one waits.
- R3: A source at priority 0 is never offered.
- R4: The highest priority wins. Among sources of equal priority, the lowest index wins.
- R5: The vector for ordinary source i is 4+i, and `int_lvl` carries its priority.
- R6: When `int_ack` is high while a request is offered, the following happens on that edge: `cpu_prio` takes the offered level, the old level is pushed, and the pending bit (or trap pending state) of the winner is cleared.
- R7: `int_ret` pops the saved level back into `cpu_prio`. An acknowledge in the same cycle takes precedence over the return.
- R8: A trap cause cannot be masked. Its event sets bit i of `tfr_q`. That bit stays set until a write to the flag word carries a 0 in bit i (the flag word becomes old AND written data), and a new event in the same cycle wins.
- R9: Any eligible trap is offered ahead of ordinary sources. While a trap is in service (`cpu_prio` >= 16), ordinary sources are never offered.
- R10: A trap is offered only when its class level is strictly above `cpu_prio`. The higher class wins, then the lower cause index.
- R11: While the save stack holds DEPTH entries, nothing is offered. A return with an empty stack leaves `cpu_prio` unchanged.
- R12: All class-I trap causes share vector 2. Class II uses vector 1 and class III uses vector 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | NSRC | Request pulses from sources |
| cfg_we | input | 1 | Control word write strobe |
| cfg_sel | input | clog2(NSRC) | Source whose control word is written or read |
| cfg_wdata | input | 6 | Control word: [5] pending, [4] enable, [3:0] priority |
| cfg_rdata | output | 6 | Selected control word |
| trap_evt | input | NTRAP | Hardware trap cause pulses |
| tfr_we | input | 1 | Trap flag write strobe (AND with data) |
| tfr_wdata | input | NTRAP | Trap flag write data |
| tfr_q | output | NTRAP | Sticky trap flags |
| int_ack | input | 1 | CPU accepts the offered request |
| int_ret | input | 1 | CPU returns from a service |
| int_req | output | 1 | A request is offered |
| int_is_trap | output | 1 | The offered request is a trap |
| int_vec | output | clog2(4+NSRC) | Vector of the offered request |
| int_lvl | output | 5 | Level of the offered request |
| cpu_prio | output | 5 | Current CPU level |

## Verification
Every stored flag, field and level changes on the edge that samples its stimulus. The offer outputs are combinational from that state, so each result is due exactly one edge after the input was driven. The bench drives inputs at the falling edge, lets one rising edge pass, and checks at the next falling edge. Sequences such as nesting, trap preemption and stack filling are built one acknowledge or return at a time, and each step is checked before the next stimulus is applied.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int LVLW      = 5;
    localparam int PRIOW     = 4;
    localparam int TRAP_LVL0 = 16;
    localparam int VEC_BASE  = 4;

    // class 3 = highest trap tier
    function automatic int trap_class(input int idx);
        if (idx == 0)      return 3;
        else if (idx == 1) return 2;
        else               return 1;
    endfunction
endpackage

// File: rtl/intc_arb.sv
module intc_arb
    import intc_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int IDXW = 3
) (
    input  logic [NSRC-1:0]            req,
    input  logic [NSRC-1:0]            en,
    input  logic [NSRC-1:0][PRIOW-1:0] prio,
    input  logic [LVLW-1:0]            cur,
    output logic                       valid,
    output logic [IDXW-1:0]            idx,
    output logic [LVLW-1:0]            lvl
);
    logic [PRIOW-1:0] best;

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && en[i] && (LVLW'(prio[i]) > cur) &&
                (!valid || prio[i] > best)) begin
                valid = 1'b1;
                idx   = IDXW'(i);
                best  = prio[i];
            end
        end
        lvl = LVLW'(best);
    end
endmodule

// File: rtl/intc_trapsel.sv
module intc_trapsel
    import intc_pkg::*;
#(
    parameter int NTRAP = 4,
    parameter int TIDXW = 2,
    parameter int VECW  = 4
) (
    input  logic [NTRAP-1:0] pend,
    input  logic [LVLW-1:0]  cur,
    output logic             valid,
    output logic [TIDXW-1:0] idx,
    output logic [LVLW-1:0]  lvl,
    output logic [VECW-1:0]  vec
);
    logic [NTRAP-1:0][LVLW-1:0] cls_lvl;
    logic [NTRAP-1:0][VECW-1:0] cls_vec;

    for (genvar g = 0; g < NTRAP; g++) begin : g_cls
        assign cls_lvl[g] = LVLW'(TRAP_LVL0 + trap_class(g) - 1);
        assign cls_vec[g] = VECW'(3 - trap_class(g));
    end

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        lvl   = '0;
        vec   = '0;
        for (int i = 0; i < NTRAP; i++) begin
            if (pend[i] && cls_lvl[i] > cur && (!valid || cls_lvl[i] > lvl)) begin
                valid = 1'b1;
                idx   = TIDXW'(i);
                lvl   = cls_lvl[i];
                vec   = cls_vec[i];
            end
        end
    end
endmodule

// File: rtl/intc_stack.sv
module intc_stack
    import intc_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic [LVLW-1:0] push_val,
    output logic [LVLW-1:0] top,
    output logic            full,
    output logic            empty
);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][LVLW-1:0] mem;
        logic [CNTW-1:0]            cnt;
    } stk_t;

    stk_t s_d, s_q;

    assign full  = (s_q.cnt == CNTW'(DEPTH));
    assign empty = (s_q.cnt == '0);
    assign top   = empty ? '0 : s_q.mem[PTRW'(s_q.cnt - 1'b1)];

    always_comb begin
        s_d = s_q;
        if (push && !full) begin
            s_d.mem[PTRW'(s_q.cnt)] = push_val;
            s_d.cnt = s_q.cnt + 1'b1;
        end else if (pop && !empty) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNTW'(DEPTH));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int NTRAP = 4,
    parameter int DEPTH = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NSRC-1:0]                      src_evt,
    input  logic                                 cfg_we,
    input  logic [$clog2(NSRC)-1:0]              cfg_sel,
    input  logic [PRIOW+1:0]                     cfg_wdata,
    output logic [PRIOW+1:0]                     cfg_rdata,
    input  logic [NTRAP-1:0]                     trap_evt,
    input  logic                                 tfr_we,
    input  logic [NTRAP-1:0]                     tfr_wdata,
    output logic [NTRAP-1:0]                     tfr_q,
    input  logic                                 int_ack,
    input  logic                                 int_ret,
    output logic                                 int_req,
    output logic                                 int_is_trap,
    output logic [$clog2(VEC_BASE+NSRC)-1:0]     int_vec,
    output logic [LVLW-1:0]                      int_lvl,
    output logic [LVLW-1:0]                      cpu_prio
);
    localparam int IDXW  = $clog2(NSRC);
    localparam int TIDXW = (NTRAP > 1) ? $clog2(NTRAP) : 1;
    localparam int VECW  = $clog2(VEC_BASE + NSRC);

    typedef struct packed {
        logic [NSRC-1:0]            req;
        logic [NSRC-1:0]            en;
        logic [NSRC-1:0][PRIOW-1:0] prio;
        logic [NTRAP-1:0]           tpend;
        logic [NTRAP-1:0]           tflag;
        logic [LVLW-1:0]            cur;
    } st_t;

    st_t st_d, st_q;

    logic             n_valid, t_valid;
    logic [IDXW-1:0]  n_idx;
    logic [TIDXW-1:0] t_idx;
    logic [LVLW-1:0]  n_lvl, t_lvl, stk_top;
    logic [VECW-1:0]  t_vec;
    logic             stk_full, stk_empty, ack_fire, pop_fire;

    intc_arb #(.NSRC(NSRC), .IDXW(IDXW)) u_arb (
        .req(st_q.req), .en(st_q.en), .prio(st_q.prio), .cur(st_q.cur),
        .valid(n_valid), .idx(n_idx), .lvl(n_lvl)
    );

    intc_trapsel #(.NTRAP(NTRAP), .TIDXW(TIDXW), .VECW(VECW)) u_trap (
        .pend(st_q.tpend), .cur(st_q.cur),
        .valid(t_valid), .idx(t_idx), .lvl(t_lvl), .vec(t_vec)
    );

    intc_stack #(.DEPTH(DEPTH)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(ack_fire), .pop(pop_fire),
        .push_val(st_q.cur), .top(stk_top), .full(stk_full), .empty(stk_empty)
    );

    assign int_req     = (t_valid || n_valid) && !stk_full;
    assign int_is_trap = t_valid;
    assign int_vec     = t_valid ? t_vec : VECW'(VEC_BASE + int'(n_idx));
    assign int_lvl     = t_valid ? t_lvl : n_lvl;
    assign cpu_prio    = st_q.cur;
    assign tfr_q       = st_q.tflag;
    assign cfg_rdata   = {st_q.req[cfg_sel], st_q.en[cfg_sel], st_q.prio[cfg_sel]};
    assign ack_fire    = int_ack && int_req;
    assign pop_fire    = int_ret && !int_ack && !stk_empty;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NSRC; i++) begin
            if (ack_fire && !t_valid && n_idx == IDXW'(i)) st_d.req[i] = 1'b0;
            if (src_evt[i])                                st_d.req[i] = 1'b1;
            if (cfg_we && cfg_sel == IDXW'(i)) begin
                st_d.req[i]  = cfg_wdata[PRIOW+1];
                st_d.en[i]   = cfg_wdata[PRIOW];
                st_d.prio[i] = cfg_wdata[PRIOW-1:0];
            end
        end
        for (int j = 0; j < NTRAP; j++) begin
            if (ack_fire && t_valid && t_idx == TIDXW'(j)) st_d.tpend[j] = 1'b0;
            if (trap_evt[j])                               st_d.tpend[j] = 1'b1;
        end
        if (tfr_we) st_d.tflag = st_q.tflag & tfr_wdata;
        st_d.tflag = st_d.tflag | trap_evt;
        if (ack_fire)      st_d.cur = int_lvl;
        else if (pop_fire) st_d.cur = stk_top;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_irq_above_cur_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && !int_is_trap) |-> (int_lvl > cpu_prio));
    p_no_lvl0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (int_lvl != '0));
    p_ack_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_req) |=> (cpu_prio == $past(int_lvl)));
    p_ret_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ret && !int_ack && !stk_empty) |=> (cpu_prio == $past(stk_top)));
    p_tflag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tfr_we |=> (($past(tfr_q) & ~tfr_q) == '0));
    p_trap_blocks_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && cpu_prio >= LVLW'(TRAP_LVL0)) |-> int_is_trap);
    p_full_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stk_full |-> !int_req);
endmodule

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
    localparam int PER   = 10;
    localparam int NSRC  = 8;
    localparam int NTRAP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_evt = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [5:0]  cfg_wdata = '0;
    logic [5:0]  cfg_rdata;
    logic [3:0]  trap_evt = '0;
    logic        tfr_we = 1'b0;
    logic [3:0]  tfr_wdata = '0;
    logic [3:0]  tfr_q;
    logic        int_ack = 1'b0, int_ret = 1'b0;
    logic        int_req, int_is_trap;
    logic [3:0]  int_vec;
    logic [4:0]  int_lvl, cpu_prio;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(PER/2) clk = ~clk;

    prio_intc #(.NSRC(NSRC), .NTRAP(NTRAP), .DEPTH(8)) u0 (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .trap_evt(trap_evt), .tfr_we(tfr_we), .tfr_wdata(tfr_wdata), .tfr_q(tfr_q),
        .int_ack(int_ack), .int_ret(int_ret), .int_req(int_req),
        .int_is_trap(int_is_trap), .int_vec(int_vec), .int_lvl(int_lvl),
        .cpu_prio(cpu_prio)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic cfg(input int sel, input bit req, input bit en, input int prio);
        cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = {req, en, 4'(prio)};
        step();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_src(input int i);
        src_evt[i] = 1'b1;
        step();
        src_evt = '0;
    endtask

    task automatic pulse_trap(input int i);
        trap_evt[i] = 1'b1;
        step();
        trap_evt = '0;
    endtask

    task automatic ack();
        int_ack = 1'b1; step(); int_ack = 1'b0;
    endtask

    task automatic ret();
        int_ret = 1'b1; step(); int_ret = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R6 reset cpu_prio", int'(cpu_prio), 0);
        chk("R2 reset int_req", int'(int_req), 0);
        chk("R8 reset tfr_q", int'(tfr_q), 0);
        chk("R1 reset cfg_rdata", int'(cfg_rdata), 0);
    endtask

    task automatic t_basic();
        do_reset();
        cfg(3, 0, 1, 5);
        chk("R1 cfg readback", int'(cfg_rdata), 'h15);
        chk("R2 not pending yet", int'(int_req), 0);
        pulse_src(3);
        cfg_sel = 3'd3;
        #1;
        chk("R1 pending set", int'(cfg_rdata), 'h35);
        chk("R2 offered", int'(int_req), 1);
        chk("R5 vector", int'(int_vec), 7);
        chk("R5 level", int'(int_lvl), 5);
        chk("R9 not trap", int'(int_is_trap), 0);
    endtask

    task automatic t_masking();
        do_reset();
        cfg(1, 0, 1, 0);
        pulse_src(1);
        chk("R3 prio0 never offered", int'(int_req), 0);
        cfg(2, 0, 0, 9);
        pulse_src(2);
        chk("R2 disabled not offered", int'(int_req), 0);
        cfg(2, 1, 1, 9);
        chk("R2 enabled offered", int'(int_req), 1);
        chk("R5 vector src2", int'(int_vec), 6);
    endtask

    task automatic t_equal();
        do_reset();
        cfg(5, 1, 1, 7);
        cfg(2, 1, 1, 7);
        chk("R4 lowest index wins", int'(int_vec), 6);
        cfg(6, 1, 1, 9);
        chk("R4 higher prio wins", int'(int_vec), 10);
        chk("R5 level 9", int'(int_lvl), 9);
    endtask

    task automatic t_nest();
        do_reset();
        cfg(4, 0, 1, 6);
        pulse_src(4);
        ack();
        chk("R6 cpu_prio after ack", int'(cpu_prio), 6);
        cfg_sel = 3'd4;
        #1;
        chk("R6 pending cleared", int'(cfg_rdata), 'h16);
        chk("R6 nothing offered", int'(int_req), 0);
        cfg(1, 1, 1, 6);
        chk("R2 same level waits", int'(int_req), 0);
        cfg(0, 1, 1, 7);
        chk("R2 higher preempts", int'(int_req), 1);
        chk("R5 vector src0", int'(int_vec), 4);
        ack();
        chk("R6 nested level", int'(cpu_prio), 7);
        ret();
        chk("R7 pop to 6", int'(cpu_prio), 6);
        chk("R2 same level still waits", int'(int_req), 0);
        ret();
        chk("R7 pop to 0", int'(cpu_prio), 0);
        chk("R2 waiting source offered", int'(int_vec), 5);
        cfg(1, 0, 1, 6);
        ret();
        chk("R11 empty return no effect", int'(cpu_prio), 0);
    endtask

    task automatic t_trap();
        do_reset();
        cfg(0, 1, 1, 15);
        ack();
        chk("R6 level 15", int'(cpu_prio), 15);
        pulse_trap(2);
        chk("R9 trap over level 15", int'(int_req), 1);
        chk("R9 is trap", int'(int_is_trap), 1);
        chk("R12 class I vector", int'(int_vec), 2);
        chk("R10 class I level", int'(int_lvl), 16);
        chk("R8 flag bit2", int'(tfr_q), 4);
        ack();
        chk("R6 trap level", int'(cpu_prio), 16);
        cfg(3, 1, 1, 14);
        chk("R9 normal blocked in trap", int'(int_req), 0);
        pulse_trap(3);
        chk("R10 same class waits", int'(int_req), 0);
        chk("R8 flag bit3", int'(tfr_q), 'hC);
        pulse_trap(0);
        chk("R10 class III preempts", int'(int_req), 1);
        chk("R12 class III vector", int'(int_vec), 0);
        chk("R10 class III level", int'(int_lvl), 18);
        ack();
        chk("R6 level 18", int'(cpu_prio), 18);
        pulse_trap(1);
        chk("R10 class II waits under III", int'(int_req), 0);
        chk("R8 all flags", int'(tfr_q), 'hF);
        ret();
        chk("R7 back to 16", int'(cpu_prio), 16);
        chk("R12 class II vector", int'(int_vec), 1);
        chk("R10 class II level", int'(int_lvl), 17);
        ack();
        ret();
        ret();
        chk("R7 back to 15", int'(cpu_prio), 15);
        chk("R12 shared vector cause3", int'(int_vec), 2);
        chk("R9 trap offered", int'(int_is_trap), 1);
        ack();
        ret();
        chk("R2 prio14 under 15 waits", int'(int_req), 0);
        chk("R8 flags survive service", int'(tfr_q), 'hF);
        tfr_we = 1'b1; tfr_wdata = 4'hB; step(); tfr_we = 1'b0;
        chk("R8 clear by zero bit", int'(tfr_q), 'hB);
        tfr_we = 1'b1; tfr_wdata = 4'h0; trap_evt = 4'h2; step();
        tfr_we = 1'b0; trap_evt = '0;
        chk("R8 event wins over clear", int'(tfr_q), 'h2);
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < 8; i++) begin
            cfg(i, 1, 1, i + 1);
            ack();
        end
        chk("R6 eight deep", int'(cpu_prio), 8);
        cfg(0, 1, 1, 9);
        chk("R11 full blocks offer", int'(int_req), 0);
        ret();
        chk("R7 pop from full", int'(cpu_prio), 7);
        chk("R11 offer after pop", int'(int_req), 1);
        chk("R5 vector after pop", int'(int_vec), 4);
    endtask

    task automatic t_ackret();
        do_reset();
        cfg(2, 1, 1, 3);
        ack();
        cfg(5, 1, 1, 4);
        int_ack = 1'b1; int_ret = 1'b1; step(); int_ack = 1'b0; int_ret = 1'b0;
        chk("R7 ack beats return", int'(cpu_prio), 4);
    endtask

    initial begin
        #(PER * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_masking();
        t_equal();
        t_nest();
        t_trap();
        t_full();
        t_ackret();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule